// File: doc/BRIEF.md
# Conditional Test Evaluation Unit

This unit answers one question for the instruction sequencer: does the selected condition hold? The decoder presents a 5-bit condition selector together with a test strobe. On the next clock edge the unit registers one "condition true" bit. The conditions are built from several sources:

- the sign, zero and overflow state of a 36-bit accumulator result;
- the signs of two loop counters;
- the bit-test compare flags;
- the parity and all-ones state of a bit-manipulation result;
- two chip status inputs: clock lock and coprocessor busy;
- a bit from an external pseudorandom source.

Two families of conditions have side effects, and these happen only on a strobed test. Testing a loop counter adds one to that counter after its sign has been sampled. Testing the random bit sends a one-cycle advance pulse to the generator, so that the generator moves to its next bit. Software or the loop logic can load either counter through a write port. A load wins over an increment that falls in the same cycle. With the strobe low the unit can be looked at freely: nothing changes state.

Top module: `cond_eval_unit`

## Requirements
- R1: While the synchronised reset is active, and until the first strobe after it, res_valid, res_true and rnd_adv are 0 and both counters read 0. Internal reset is released two clock edges after rst_n rises.
- R2: A test presented with test_stb high at a rising edge appears on res_true after that edge, with res_valid high for exactly that one cycle. Without a strobe, res_valid is 0 and res_true holds its last value.
- R3: Code 2 (non-negative) is true when acc_res bit 35 is 0, and code 3 (negative) when it is 1. Code 4 is true for a zero result and code 5 for a non-zero one. Code 6 is true for a result strictly greater than zero, and code 7 for a result less than or equal to zero.
- R4: Code 8 is true when acc_lov (36-bit overflow) is 1, and code 9 when it is 0. Code 10 is true when acc_res bits 35 down to 31 are not all equal (32-bit overflow), and code 11 when they are all equal.
- R5: Codes 12/13 test counter 0 for being at least zero or below zero, and codes 14/15 do the same for counter 1. The test uses the counter value before the edge. A strobed test then adds one to the tested counter, wrapping from 127 to -128. The other counter is left unchanged.
- R6: With cnt_ld_en high, the counter chosen by cnt_ld_sel (0 or 1) takes cnt_ld_data at the edge. This load has priority over an increment from a test in the same cycle.
- R7: Code 16 is true when rnd_bit is 1, and code 17 when it is 0. A strobed test with code 16 or 17 raises rnd_adv for the one cycle after the edge. No other code raises it.
- R8: The tested bits are those set in bt_mask, and a tested bit compared successfully when its bt_hit bit is set. Code 18 is true when every tested bit compared successfully, and code 19 when none did. Code 20 is true when at least one did, and code 21 when at least one did not.
- R9: Code 22 is true when bmu_res has an odd number of ones, and code 23 when that number is even. Code 24 is true when bmu_res is all ones (minus one), and code 25 when it is not.
- R10: Code 0 is always true and code 1 never is. Codes 26/27 are true when pll_lock is 1 or 0 respectively, and codes 28/29 when ecc_busy is 1 or 0. Codes 30 and 31 are reserved and evaluate false.
- R11: With test_stb low, no code changes a counter or raises rnd_adv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_stb | input | 1 | Test strobe; qualifies evaluation and side effects |
| test_code | input | 5 | Condition selector |
| acc_res | input | 36 | Accumulator result (two's complement) |
| acc_lov | input | 1 | 36-bit overflow flag of that result |
| bt_mask | input | 4 | Bits under test |
| bt_hit | input | 4 | Per-bit compare success |
| bmu_res | input | 36 | Bit-manipulation result |
| pll_lock | input | 1 | Clock PLL locked |
| ecc_busy | input | 1 | Error-correction coprocessor active |
| rnd_bit | input | 1 | Current pseudorandom bit |
| cnt_ld_en | input | 1 | Counter load enable |
| cnt_ld_sel | input | 1 | Counter to load (0 or 1) |
| cnt_ld_data | input | 8 | Load value (signed) |
| res_valid | output | 1 | Result valid pulse |
| res_true | output | 1 | Condition true |
| rnd_adv | output | 1 | Advance pulse to the random source |
| cnt0_o | output | 8 | Counter 0 value |
| cnt1_o | output | 8 | Counter 1 value |

## Verification
Every result is due exactly one edge after the strobe. This covers res_true and res_valid, the rnd_adv pulse, and the new counter values after an increment or a load. The bench drives each operation on a falling edge. It computes the expected outputs from the inputs and its own model of the counters as they stood before the edge. It samples on the next falling edge, one rising edge later. Release of the reset synchroniser is waited out before the first sampled check.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  localparam int CODE_W = 5;
  localparam int CC_NUM = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    CC_TRUE   = 5'd0,  CC_FALSE  = 5'd1,
    CC_PL     = 5'd2,  CC_MI     = 5'd3,
    CC_EQ     = 5'd4,  CC_NE     = 5'd5,
    CC_GT     = 5'd6,  CC_LE     = 5'd7,
    CC_LVS    = 5'd8,  CC_LVC    = 5'd9,
    CC_MVS    = 5'd10, CC_MVC    = 5'd11,
    CC_C0GE   = 5'd12, CC_C0LT   = 5'd13,
    CC_C1GE   = 5'd14, CC_C1LT   = 5'd15,
    CC_HEADS  = 5'd16, CC_TAILS  = 5'd17,
    CC_ALLT   = 5'd18, CC_ALLF   = 5'd19,
    CC_SOMET  = 5'd20, CC_SOMEF  = 5'd21,
    CC_ODDP   = 5'd22, CC_EVENP  = 5'd23,
    CC_MNS1   = 5'd24, CC_NMNS1  = 5'd25,
    CC_LOCK   = 5'd26, CC_NLOCK  = 5'd27,
    CC_EBUSY  = 5'd28, CC_NEBUSY = 5'd29,
    CC_RSV0   = 5'd30, CC_RSV1   = 5'd31
  } cond_code_e;

  // Codes 12..15 share prefix 011; bit 1 names the counter.
  function automatic logic is_cnt_test(input logic [CODE_W-1:0] code,
                                       input logic idx);
    return (code[4:2] == 3'b011) && (code[1] == idx);
  endfunction

  // Codes 16 and 17 consume the random bit.
  function automatic logic is_rnd_test(input logic [CODE_W-1:0] code);
    return code[4:1] == 4'b1000;
  endfunction

endpackage

// File: rtl/cond_arith_flags.sv
module cond_arith_flags #(
  parameter int ACC_W = 36,
  parameter int MOV_W = 5
) (
  input  logic [ACC_W-1:0] acc_res,
  output logic             neg,
  output logic             zero,
  output logic             mov
);

  localparam int OVF_LO = ACC_W - MOV_W;

  logic [MOV_W-1:0] top_bits;

  always_comb begin
    top_bits = acc_res[ACC_W-1:OVF_LO];
    neg      = acc_res[ACC_W-1];
    zero     = (acc_res == '0);
    mov      = !((top_bits == '0) || (top_bits == '1));
  end

endmodule

// File: rtl/cond_bit_flags.sv
module cond_bit_flags #(
  parameter int BT_W  = 4,
  parameter int BMU_W = 36
) (
  input  logic [BT_W-1:0]  bt_mask,
  input  logic [BT_W-1:0]  bt_hit,
  input  logic [BMU_W-1:0] bmu_res,
  output logic             all_pass,
  output logic             none_pass,
  output logic             some_pass,
  output logic             some_fail,
  output logic             odd_par,
  output logic             minus_one
);

  logic [BT_W-1:0] pass_v;
  logic [BT_W-1:0] fail_v;

  always_comb begin
    pass_v    = bt_mask & bt_hit;
    fail_v    = bt_mask & ~bt_hit;
    all_pass  = (fail_v == '0);
    none_pass = (pass_v == '0);
    some_pass = |pass_v;
    some_fail = |fail_v;
    odd_par   = ^bmu_res;
    minus_one = &bmu_res;
  end

endmodule

// File: rtl/cond_loop_counters.sv
module cond_loop_counters #(
  parameter int CNT_W = 8,
  parameter int N_CNT = 2
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic [N_CNT-1:0]            inc,
  input  logic                        ld_en,
  input  logic [$clog2(N_CNT)-1:0]    ld_sel,
  input  logic [CNT_W-1:0]            ld_data,
  output logic [N_CNT-1:0][CNT_W-1:0] cnt_q
);

  localparam int SEL_W = $clog2(N_CNT);

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_en;
    logic             ld_hit;

    always_comb begin
      ld_hit = ld_en && (ld_sel == SEL_W'(g));
      cnt_en = ld_hit || inc[g];
      if (ld_hit) begin
        cnt_d = ld_data;
      end else begin
        cnt_d = cnt_q[g] + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (cnt_en) begin
        cnt_q[g] <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
  import cond_eval_pkg::*;
#(
  parameter int ACC_W = 36,
  parameter int MOV_W = 5,
  parameter int BT_W  = 4,
  parameter int BMU_W = 36,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_stb,
  input  logic [4:0]       test_code,
  input  logic [ACC_W-1:0] acc_res,
  input  logic             acc_lov,
  input  logic [BT_W-1:0]  bt_mask,
  input  logic [BT_W-1:0]  bt_hit,
  input  logic [BMU_W-1:0] bmu_res,
  input  logic             pll_lock,
  input  logic             ecc_busy,
  input  logic             rnd_bit,
  input  logic             cnt_ld_en,
  input  logic             cnt_ld_sel,
  input  logic [CNT_W-1:0] cnt_ld_data,
  output logic             res_valid,
  output logic             res_true,
  output logic             rnd_adv,
  output logic [CNT_W-1:0] cnt0_o,
  output logic [CNT_W-1:0] cnt1_o
);

  localparam int N_CNT = 2;
  localparam int SYNC_W = 2;

  // Reset: asserted asynchronously, released through a short synchroniser.
  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[SYNC_W-1];

  // Flag sources
  logic neg, zero, mov;
  logic all_pass, none_pass, some_pass, some_fail, odd_par, minus_one;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [N_CNT-1:0]            cnt_inc;

  cond_arith_flags #(.ACC_W(ACC_W), .MOV_W(MOV_W)) u_arith (
    .acc_res (acc_res),
    .neg     (neg),
    .zero    (zero),
    .mov     (mov)
  );

  cond_bit_flags #(.BT_W(BT_W), .BMU_W(BMU_W)) u_bits (
    .bt_mask   (bt_mask),
    .bt_hit    (bt_hit),
    .bmu_res   (bmu_res),
    .all_pass  (all_pass),
    .none_pass (none_pass),
    .some_pass (some_pass),
    .some_fail (some_fail),
    .odd_par   (odd_par),
    .minus_one (minus_one)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_inc
    assign cnt_inc[g] = test_stb && is_cnt_test(test_code, g[0]);
  end

  cond_loop_counters #(.CNT_W(CNT_W), .N_CNT(N_CNT)) u_cnt (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .inc     (cnt_inc),
    .ld_en   (cnt_ld_en),
    .ld_sel  (cnt_ld_sel),
    .ld_data (cnt_ld_data),
    .cnt_q   (cnt_q)
  );

  assign cnt0_o = cnt_q[0];
  assign cnt1_o = cnt_q[1];

  // Condition vector, indexed by selector
  logic [CC_NUM-1:0] cvec;
  logic              sel_val;

  always_comb begin
    cvec            = '0;
    cvec[CC_TRUE]   = 1'b1;
    cvec[CC_FALSE]  = 1'b0;
    cvec[CC_PL]     = !neg;
    cvec[CC_MI]     = neg;
    cvec[CC_EQ]     = zero;
    cvec[CC_NE]     = !zero;
    cvec[CC_GT]     = !neg && !zero;
    cvec[CC_LE]     = neg || zero;
    cvec[CC_LVS]    = acc_lov;
    cvec[CC_LVC]    = !acc_lov;
    cvec[CC_MVS]    = mov;
    cvec[CC_MVC]    = !mov;
    cvec[CC_C0GE]   = !cnt_q[0][CNT_W-1];
    cvec[CC_C0LT]   = cnt_q[0][CNT_W-1];
    cvec[CC_C1GE]   = !cnt_q[1][CNT_W-1];
    cvec[CC_C1LT]   = cnt_q[1][CNT_W-1];
    cvec[CC_HEADS]  = rnd_bit;
    cvec[CC_TAILS]  = !rnd_bit;
    cvec[CC_ALLT]   = all_pass;
    cvec[CC_ALLF]   = none_pass;
    cvec[CC_SOMET]  = some_pass;
    cvec[CC_SOMEF]  = some_fail;
    cvec[CC_ODDP]   = odd_par;
    cvec[CC_EVENP]  = !odd_par;
    cvec[CC_MNS1]   = minus_one;
    cvec[CC_NMNS1]  = !minus_one;
    cvec[CC_LOCK]   = pll_lock;
    cvec[CC_NLOCK]  = !pll_lock;
    cvec[CC_EBUSY]  = ecc_busy;
    cvec[CC_NEBUSY] = !ecc_busy;
    cvec[CC_RSV0]   = 1'b0;
    cvec[CC_RSV1]   = 1'b0;
    sel_val         = cvec[test_code];
  end

  // Result registers: next-state then storage
  logic valid_d, true_d, adv_d;
  logic valid_q, true_q, adv_q;

  always_comb begin
    valid_d = test_stb;
    true_d  = test_stb ? sel_val : true_q;
    adv_d   = test_stb && is_rnd_test(test_code);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      true_q  <= 1'b0;
      adv_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      true_q  <= true_d;
      adv_q   <= adv_d;
    end
  end

  assign res_valid = valid_q;
  assign res_true  = true_q;
  assign rnd_adv   = adv_q;

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int ACC_W = 36,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             test_stb,
  input logic [4:0]       test_code,
  input logic [ACC_W-1:0] acc_res,
  input logic             cnt_ld_en,
  input logic             cnt_ld_sel,
  input logic [CNT_W-1:0] cnt_ld_data,
  input logic             res_valid,
  input logic             res_true,
  input logic             rnd_adv,
  input logic [CNT_W-1:0] cnt0_o,
  input logic [CNT_W-1:0] cnt1_o
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    test_stb |=> res_valid);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !test_stb |=> (!res_valid && $stable(res_true)));

  a_r3_eq_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (test_stb && test_code == 5'd4) |=> (res_true == ($past(acc_res) == '0)));

  a_r5_cnt0_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (test_stb && test_code[4:1] == 4'b0110 && !cnt_ld_en)
      |=> (cnt0_o == $past(cnt0_o) + CNT_W'(1)) && $stable(cnt1_o));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_ld_en && !cnt_ld_sel) |=> (cnt0_o == $past(cnt_ld_data)));

  a_r7_adv_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    (test_stb && test_code[4:1] == 4'b1000) |=> rnd_adv);

  a_r7_adv_only_rnd: assert property (@(posedge clk) disable iff (!rst_ni)
    rnd_adv |-> res_valid);

  a_r10_always_true: assert property (@(posedge clk) disable iff (!rst_ni)
    (test_stb && test_code == 5'd0) |=> res_true);

  a_r11_no_side_effect: assert property (@(posedge clk) disable iff (!rst_ni)
    (!test_stb && !cnt_ld_en) |=> ($stable(cnt0_o) && $stable(cnt1_o) && !rnd_adv));

endmodule

bind cond_eval_unit cond_eval_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .test_stb    (test_stb),
  .test_code   (test_code),
  .acc_res     (acc_res),
  .cnt_ld_en   (cnt_ld_en),
  .cnt_ld_sel  (cnt_ld_sel),
  .cnt_ld_data (cnt_ld_data),
  .res_valid   (res_valid),
  .res_true    (res_true),
  .rnd_adv     (rnd_adv),
  .cnt0_o      (cnt0_o),
  .cnt1_o      (cnt1_o)
);

// File: tb/cond_eval_unit_tb.sv
module cond_eval_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_stb = 1'b0;
  logic [4:0]  test_code = '0;
  logic [35:0] acc_res = '0;
  logic        acc_lov = 1'b0;
  logic [3:0]  bt_mask = '0;
  logic [3:0]  bt_hit = '0;
  logic [35:0] bmu_res = '0;
  logic        pll_lock = 1'b0;
  logic        ecc_busy = 1'b0;
  logic        rnd_bit = 1'b0;
  logic        cnt_ld_en = 1'b0;
  logic        cnt_ld_sel = 1'b0;
  logic [7:0]  cnt_ld_data = '0;
  logic        res_valid, res_true, rnd_adv;
  logic [7:0]  cnt0_o, cnt1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_c0 = '0;
  logic [7:0] m_c1 = '0;
  logic       m_true = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_eval_unit dut_i (
    .clk(clk), .rst_n(rst_n), .test_stb(test_stb), .test_code(test_code),
    .acc_res(acc_res), .acc_lov(acc_lov), .bt_mask(bt_mask), .bt_hit(bt_hit),
    .bmu_res(bmu_res), .pll_lock(pll_lock), .ecc_busy(ecc_busy),
    .rnd_bit(rnd_bit), .cnt_ld_en(cnt_ld_en), .cnt_ld_sel(cnt_ld_sel),
    .cnt_ld_data(cnt_ld_data), .res_valid(res_valid), .res_true(res_true),
    .rnd_adv(rnd_adv), .cnt0_o(cnt0_o), .cnt1_o(cnt1_o)
  );

  function automatic string req_of(input logic [4:0] c);
    if (c <= 5'd1)  return "R10";
    if (c <= 5'd7)  return "R3";
    if (c <= 5'd11) return "R4";
    if (c <= 5'd15) return "R5";
    if (c <= 5'd17) return "R7";
    if (c <= 5'd21) return "R8";
    if (c <= 5'd25) return "R9";
    return "R10";
  endfunction

  function automatic logic exp_cond(input logic [4:0] c);
    logic [4:0] top5;
    top5 = acc_res[35:31];
    case (c)
      5'd0:  return 1'b1;
      5'd1:  return 1'b0;
      5'd2:  return acc_res[35] == 1'b0;
      5'd3:  return acc_res[35] == 1'b1;
      5'd4:  return acc_res == 36'd0;
      5'd5:  return acc_res != 36'd0;
      5'd6:  return $signed(acc_res) > 36'sd0;
      5'd7:  return $signed(acc_res) <= 36'sd0;
      5'd8:  return acc_lov;
      5'd9:  return !acc_lov;
      5'd10: return !(top5 == 5'b00000 || top5 == 5'b11111);
      5'd11: return (top5 == 5'b00000 || top5 == 5'b11111);
      5'd12: return $signed(m_c0) >= 0;
      5'd13: return $signed(m_c0) < 0;
      5'd14: return $signed(m_c1) >= 0;
      5'd15: return $signed(m_c1) < 0;
      5'd16: return rnd_bit;
      5'd17: return !rnd_bit;
      5'd18: return (bt_mask & ~bt_hit) == 4'd0;
      5'd19: return (bt_mask & bt_hit) == 4'd0;
      5'd20: return (bt_mask & bt_hit) != 4'd0;
      5'd21: return (bt_mask & ~bt_hit) != 4'd0;
      5'd22: return ($countones(bmu_res) % 2) == 1;
      5'd23: return ($countones(bmu_res) % 2) == 0;
      5'd24: return bmu_res == {36{1'b1}};
      5'd25: return bmu_res != {36{1'b1}};
      5'd26: return pll_lock;
      5'd27: return !pll_lock;
      5'd28: return ecc_busy;
      5'd29: return !ecc_busy;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rand_data();
    logic [63:0] w;
    w = {$urandom, $urandom};
    case ($urandom % 5)
      0: acc_res = 36'd0;
      1: acc_res = {5'b00000, w[30:0]};
      2: acc_res = {5'b11111, w[30:0]};
      3: acc_res = w[35:0];
      default: acc_res = {36{1'b1}};
    endcase
    acc_lov  = $urandom % 2;
    bt_mask  = 4'($urandom);
    bt_hit   = 4'($urandom);
    w = {$urandom, $urandom};
    bmu_res  = ($urandom % 4 == 0) ? {36{1'b1}} : w[35:0];
    pll_lock = $urandom % 2;
    ecc_busy = $urandom % 2;
    rnd_bit  = $urandom % 2;
  endtask

  // Drive one operation on a falling edge, sample on the next falling edge.
  task automatic run_op(input logic stb, input logic [4:0] code,
                        input logic ld, input logic lsel, input logic [7:0] ldat);
    logic       e_true, e_adv;
    logic [7:0] n_c0, n_c1;
    string      rq;
    @(negedge clk);
    test_stb = stb; test_code = code;
    cnt_ld_en = ld; cnt_ld_sel = lsel; cnt_ld_data = ldat;
    rq     = stb ? req_of(code) : "R11";
    e_true = stb ? exp_cond(code) : m_true;
    e_adv  = stb && (code == 5'd16 || code == 5'd17);
    n_c0 = m_c0; n_c1 = m_c1;
    if (stb && (code == 5'd12 || code == 5'd13)) n_c0 = m_c0 + 8'd1;
    if (stb && (code == 5'd14 || code == 5'd15)) n_c1 = m_c1 + 8'd1;
    if (ld && !lsel) n_c0 = ldat;
    if (ld && lsel)  n_c1 = ldat;
    @(negedge clk);
    test_stb = 1'b0; cnt_ld_en = 1'b0;
    chk("R2", "res_valid", 64'(res_valid), 64'(stb));
    chk(rq, $sformatf("res_true code %0d", code), 64'(res_true), 64'(e_true));
    chk(stb ? "R7" : "R11", "rnd_adv", 64'(rnd_adv), 64'(e_adv));
    chk(ld ? "R6" : (stb ? "R5" : "R11"), "cnt0", 64'(cnt0_o), 64'(n_c0));
    chk(ld ? "R6" : (stb ? "R5" : "R11"), "cnt1", 64'(cnt1_o), 64'(n_c1));
    m_c0 = n_c0; m_c1 = n_c1; m_true = e_true;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "res_valid", 64'(res_valid), 64'd0);
    chk("R1", "res_true", 64'(res_true), 64'd0);
    chk("R1", "rnd_adv", 64'(rnd_adv), 64'd0);
    chk("R1", "cnt0", 64'(cnt0_o), 64'd0);
    chk("R1", "cnt1", 64'(cnt1_o), 64'd0);

    // R3: zero is not greater than zero; R10 true/false
    acc_res = 36'd0;
    run_op(1, 5'd6, 0, 0, 8'd0);
    run_op(1, 5'd7, 0, 0, 8'd0);
    run_op(1, 5'd0, 0, 0, 8'd0);
    run_op(1, 5'd1, 0, 0, 8'd0);
    // R4: 32-bit overflow boundary
    acc_res = 36'h07FFFFFFF;
    run_op(1, 5'd10, 0, 0, 8'd0);
    acc_res = 36'h080000000;
    run_op(1, 5'd10, 0, 0, 8'd0);
    acc_res = 36'hF80000000;
    run_op(1, 5'd11, 0, 0, 8'd0);
    // R5: counter wrap from 127, sampled before increment
    run_op(0, 5'd12, 1, 0, 8'd127);
    run_op(1, 5'd12, 0, 0, 8'd0);
    run_op(1, 5'd13, 0, 0, 8'd0);
    // R6: load beats same-cycle increment
    run_op(1, 5'd14, 1, 1, 8'd200);
    run_op(1, 5'd15, 0, 0, 8'd0);
    // R11: no strobe, counter code and random code
    run_op(0, 5'd12, 0, 0, 8'd0);
    run_op(0, 5'd16, 0, 0, 8'd0);
    // R7: heads with bit set, tails with bit set
    rnd_bit = 1'b1;
    run_op(1, 5'd16, 0, 0, 8'd0);
    run_op(1, 5'd17, 0, 0, 8'd0);
    // R8: empty mask
    bt_mask = 4'd0; bt_hit = 4'hF;
    run_op(1, 5'd18, 0, 0, 8'd0);
    run_op(1, 5'd20, 0, 0, 8'd0);
    // R9: minus one is even parity (36 ones)
    bmu_res = {36{1'b1}};
    run_op(1, 5'd24, 0, 0, 8'd0);
    run_op(1, 5'd23, 0, 0, 8'd0);
    // R10: reserved codes
    run_op(1, 5'd30, 0, 0, 8'd0);
    run_op(1, 5'd31, 0, 0, 8'd0);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic       stb, ld, lsel;
      logic [4:0] code;
      rand_data();
      stb  = ($urandom % 8) != 0;
      code = 5'($urandom);
      ld   = ($urandom % 6) == 0;
      lsel = $urandom % 2;
      run_op(stb, code, ld, lsel, 8'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule